// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, per received frame, whether the frame is kept or dropped, judging only by its destination address and its length. The six destination bytes arrive one per cycle, in wire order, on a byte stream with a valid qualifier. A start strobe marks the first byte. The frame length is presented alongside the last address byte. A station address, a 64-entry multicast hash table and four receive-mode switches decide the outcome. These switches are promiscuous, broadcast enable, multicast enable and short-frame accept.

The verdict comes one cycle after the last address byte as a single-cycle valid pulse. It carries an accept bit and a multicast flag. Multicast destinations are screened by an imperfect hash filter. A CRC-32 is run over the address as the bytes stream in, and its top six bits pick one bit of the hash table. Bytes that follow the address are ignored until the next start strobe. A start strobe in the middle of an address abandons the partial one.

Top module: `eth_dest_filter`

## Requirements
- R1: `verdict_valid` is high for exactly one cycle, the cycle after the sixth address byte is taken. It stays low at every other time, including while further bytes of the same frame are offered.
- R2: A byte offered with `byte_valid` and `byte_start` both high always becomes address byte 0. Any partial address is discarded, the CRC restarts from all ones, and no verdict is produced for the abandoned address.
- R3: When the `frame_len` sampled with the sixth byte is below 40 and `cfg_runt_ok` is 0, the frame is rejected. This rule takes precedence over every other rule. A length of exactly 40 is not short.
- R4: With `cfg_promisc` = 1, every frame that R3 does not drop is accepted, whatever its address.
- R5: With `cfg_promisc` = 0, an address of six 0xFF bytes is a broadcast. It is accepted exactly when `cfg_bcast_en` = 1.
- R6: With `cfg_promisc` = 0, a non-broadcast address whose byte 0 has bit 0 set is a multicast. It is rejected when `cfg_mcast_en` = 0.
- R7: A multicast with `cfg_mcast_en` = 1 is accepted exactly when `hash_table[idx]` = 1. The index `idx` is bits 31:26 of a CRC-32 taken over the six address bytes, byte 0 first and each byte least-significant bit first. The CRC uses polynomial 0x04C11DB7, a preset of all ones, and no final inversion. Table bit `idx` is bit `idx` mod 8 of table byte `idx` div 8, and table byte k is `hash_table[8k+7:8k]`.
- R8: Any other address is accepted only when address byte k equals `station_addr[8k+7:8k]` for all six k.
- R9: `verdict_mcast` equals bit 0 of address byte 0 whenever `verdict_valid` is high, whatever the accept decision. It is therefore 1 for a broadcast.
- R10: While `rst_n` is low and after it is released, all three outputs are 0 until a verdict is produced.
- R11: The mode switches, the tables and `frame_len` are sampled in the cycle of the sixth byte. Changing them afterwards does not alter that verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_start | input | 1 | Marks the offered byte as address byte 0 |
| byte_valid | input | 1 | A destination byte is offered this cycle |
| byte_data | input | 8 | Destination byte |
| frame_len | input | 16 | Frame length in bytes, sampled with the sixth byte |
| cfg_promisc | input | 1 | Accept any address |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_en | input | 1 | Allow multicast through the hash filter |
| cfg_runt_ok | input | 1 | Keep frames shorter than 40 bytes |
| station_addr | input | 48 | Own unicast address, byte k at bits 8k+7:8k |
| hash_table | input | 64 | Multicast hash table, bit i selected by index i |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | 1 = keep the frame |
| verdict_mcast | output | 1 | Group bit of address byte 0 |

## Verification
Most internal faults surface on the very next verdict. A stuck or miscounted byte counter moves or drops the `verdict_valid` pulse, so the cycle-exact comparison catches it within one frame. A corrupted CRC register or a wrongly selected station byte keeps the pulse timing intact but flips `verdict_accept` for certain multicast or unicast addresses. Catching those needs addresses that hit both a set and a cleared hash bit, and addresses that differ from the station address in the first and in the last byte. A stale accumulator left over from an abandoned address shows only after a mid-address restart, so that pattern is driven explicitly.

// File: rtl/edf_pkg.sv
package edf_pkg;

   localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

   typedef enum logic [2:0] {
      RULE_RUNT,
      RULE_PROMISC,
      RULE_BCAST,
      RULE_MCAST_OFF,
      RULE_HASH,
      RULE_UNICAST
   } rule_e;

   function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
      logic fb;
      fb = c[31] ^ d;
      return {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
   endfunction

   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         r = crc_bit(r, d[i]);
      end
      return r;
   endfunction

endpackage

// File: rtl/edf_crc_engine.sv
module edf_crc_engine #(
   parameter int IDX_W     = 6,
   parameter bit CRC_CHAIN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [7:0]       data,
   output logic [IDX_W-1:0] hash_idx
);
   import edf_pkg::*;

   logic [31:0] crc_q;
   logic [31:0] crc_in;
   logic [31:0] crc_next;

   assign crc_in = load ? CRC_SEED : crc_q;

   generate
      if (CRC_CHAIN) begin : g_chain
         logic [31:0] stage [0:8];
         assign stage[0] = crc_in;
         for (genvar b = 0; b < 8; b++) begin : g_bit
            assign stage[b+1] = crc_bit(stage[b], data[b]);
         end
         assign crc_next = stage[8];
      end else begin : g_func
         assign crc_next = crc_byte(crc_in, data);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= CRC_SEED;
      end else if (load || step) begin
         crc_q <= crc_next;
      end
   end

   assign hash_idx = crc_next[31 -: IDX_W];

   AST_LOAD_SEEDS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (crc_q == crc_byte(CRC_SEED, $past(data)))); // R2

endmodule

// File: rtl/edf_addr_track.sv
module edf_addr_track #(
   parameter int ADDR_BYTES = 6,
   parameter int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_start,
   input  logic                    byte_valid,
   input  logic [7:0]              byte_data,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   output logic                    load,
   output logic                    step,
   output logic                    last,
   output logic                    ones_now,
   output logic                    match_now,
   output logic                    gbit_now
);
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx;
   logic [7:0]       st_byte;
   logic             take;
   logic             ones_q, match_q, gbit_q;

   assign load = byte_valid && byte_start;
   assign step = byte_valid && !byte_start && (cnt_q != '0) && (cnt_q < CNT_DONE);
   assign take = load || step;
   assign idx  = load ? '0 : cnt_q;
   assign last = take && (idx == CNT_LAST);

   always_comb begin
      st_byte = station_addr[7:0];
      for (int k = 0; k < ADDR_BYTES; k++) begin
         if (idx == CNT_W'(k)) begin
            st_byte = station_addr[8*k +: 8];
         end
      end
   end

   assign ones_now  = (load ? 1'b1 : ones_q)  && (byte_data == 8'hFF);
   assign match_now = (load ? 1'b1 : match_q) && (byte_data == st_byte);
   assign gbit_now  = load ? byte_data[0] : gbit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ones_q  <= 1'b0;
         match_q <= 1'b0;
         gbit_q  <= 1'b0;
      end else if (take) begin
         cnt_q   <= idx + CNT_W'(1);
         ones_q  <= ones_now;
         match_q <= match_now;
         gbit_q  <= gbit_now;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_DONE); // R1
   AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_start) |=> (cnt_q == CNT_W'(1))); // R2
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q == CNT_DONE) && !(byte_valid && byte_start)) |=> (cnt_q == CNT_DONE)); // R1

endmodule

// File: rtl/edf_verdict.sv
module edf_verdict #(
   parameter int HASH_BITS = 64,
   parameter int IDX_W     = $clog2(HASH_BITS),
   parameter int LEN_W     = 16,
   parameter int RUNT_LEN  = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 last,
   input  logic                 ones_now,
   input  logic                 match_now,
   input  logic                 gbit_now,
   input  logic [IDX_W-1:0]     hash_idx,
   input  logic [HASH_BITS-1:0] hash_table,
   input  logic [LEN_W-1:0]     frame_len,
   input  logic                 cfg_promisc,
   input  logic                 cfg_bcast_en,
   input  logic                 cfg_mcast_en,
   input  logic                 cfg_runt_ok,
   output logic                 verdict_valid,
   output logic                 verdict_accept,
   output logic                 verdict_mcast
);
   import edf_pkg::*;

   rule_e rule;
   logic  keep;

   always_comb begin
      if ((frame_len < LEN_W'(RUNT_LEN)) && !cfg_runt_ok) begin
         rule = RULE_RUNT;
      end else if (cfg_promisc) begin
         rule = RULE_PROMISC;
      end else if (ones_now) begin
         rule = RULE_BCAST;
      end else if (gbit_now && !cfg_mcast_en) begin
         rule = RULE_MCAST_OFF;
      end else if (gbit_now) begin
         rule = RULE_HASH;
      end else begin
         rule = RULE_UNICAST;
      end
   end

   always_comb begin
      unique case (rule)
         RULE_RUNT:      keep = 1'b0;
         RULE_PROMISC:   keep = 1'b1;
         RULE_BCAST:     keep = cfg_bcast_en;
         RULE_MCAST_OFF: keep = 1'b0;
         RULE_HASH:      keep = hash_table[hash_idx];
         RULE_UNICAST:   keep = match_now;
         default:        keep = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_valid  <= 1'b0;
         verdict_accept <= 1'b0;
         verdict_mcast  <= 1'b0;
      end else begin
         verdict_valid <= last;
         if (last) begin
            verdict_accept <= keep;
            verdict_mcast  <= gbit_now;
         end else begin
            verdict_accept <= 1'b0;
            verdict_mcast  <= 1'b0;
         end
      end
   end

   AST_RUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (last && (frame_len < LEN_W'(RUNT_LEN)) && !cfg_runt_ok) |=> (verdict_valid && !verdict_accept)); // R3
   AST_PROMISC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (last && cfg_promisc && (cfg_runt_ok || (frame_len >= LEN_W'(RUNT_LEN)))) |=> verdict_accept); // R4
   AST_BCAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !cfg_promisc && ones_now && !cfg_bcast_en) |=> !verdict_accept); // R5
   AST_MCAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !cfg_promisc && !ones_now && gbit_now && !cfg_mcast_en) |=> !verdict_accept); // R6
   AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_accept |-> verdict_valid); // R1

endmodule

// File: rtl/eth_dest_filter.sv
module eth_dest_filter #(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 64,
   parameter int LEN_W      = 16,
   parameter int RUNT_LEN   = 40,
   parameter bit CRC_CHAIN  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_start,
   input  logic                    byte_valid,
   input  logic [7:0]              byte_data,
   input  logic [LEN_W-1:0]        frame_len,
   input  logic                    cfg_promisc,
   input  logic                    cfg_bcast_en,
   input  logic                    cfg_mcast_en,
   input  logic                    cfg_runt_ok,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   input  logic [HASH_BITS-1:0]    hash_table,
   output logic                    verdict_valid,
   output logic                    verdict_accept,
   output logic                    verdict_mcast
);
   localparam int IDX_W = $clog2(HASH_BITS);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);

   generate
      if (ADDR_BYTES < 2) begin : g_bad_len
         $error("ADDR_BYTES must be at least 2");
      end
      if ((HASH_BITS < 2) || (IDX_W > 32) || ((HASH_BITS & (HASH_BITS - 1)) != 0)) begin : g_bad_hash
         $error("HASH_BITS must be a power of two between 2 and 2**32");
      end
      if (RUNT_LEN >= (2 ** LEN_W)) begin : g_bad_runt
         $error("RUNT_LEN does not fit in LEN_W bits");
      end
   endgenerate

   logic             load, step, last;
   logic             ones_now, match_now, gbit_now;
   logic [IDX_W-1:0] hash_idx;

   edf_addr_track #(
      .ADDR_BYTES (ADDR_BYTES),
      .CNT_W      (CNT_W)
   ) track_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .byte_start   (byte_start),
      .byte_valid   (byte_valid),
      .byte_data    (byte_data),
      .station_addr (station_addr),
      .load         (load),
      .step         (step),
      .last         (last),
      .ones_now     (ones_now),
      .match_now    (match_now),
      .gbit_now     (gbit_now)
   );

   edf_crc_engine #(
      .IDX_W     (IDX_W),
      .CRC_CHAIN (CRC_CHAIN)
   ) crc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .data     (byte_data),
      .hash_idx (hash_idx)
   );

   edf_verdict #(
      .HASH_BITS (HASH_BITS),
      .IDX_W     (IDX_W),
      .LEN_W     (LEN_W),
      .RUNT_LEN  (RUNT_LEN)
   ) verdict_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .last           (last),
      .ones_now       (ones_now),
      .match_now      (match_now),
      .gbit_now       (gbit_now),
      .hash_idx       (hash_idx),
      .hash_table     (hash_table),
      .frame_len      (frame_len),
      .cfg_promisc    (cfg_promisc),
      .cfg_bcast_en   (cfg_bcast_en),
      .cfg_mcast_en   (cfg_mcast_en),
      .cfg_runt_ok    (cfg_runt_ok),
      .verdict_valid  (verdict_valid),
      .verdict_accept (verdict_accept),
      .verdict_mcast  (verdict_mcast)
   );

   AST_LAST_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> verdict_valid); // R1
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid |=> !verdict_valid); // R1

endmodule

// File: tb/eth_dest_filter_tb.sv
module eth_dest_filter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_start = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic [15:0] frame_len = 16'd64;
   logic        cfg_promisc = 1'b0;
   logic        cfg_bcast_en = 1'b0;
   logic        cfg_mcast_en = 1'b0;
   logic        cfg_runt_ok = 1'b0;
   logic [47:0] station_addr = 48'h0;
   logic [63:0] hash_table = 64'h0;
   logic        verdict_valid, verdict_accept, verdict_mcast;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string test_tag = "";

   always #5 clk = ~clk;

   eth_dest_filter dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .byte_start     (byte_start),
      .byte_valid     (byte_valid),
      .byte_data      (byte_data),
      .frame_len      (frame_len),
      .cfg_promisc    (cfg_promisc),
      .cfg_bcast_en   (cfg_bcast_en),
      .cfg_mcast_en   (cfg_mcast_en),
      .cfg_runt_ok    (cfg_runt_ok),
      .station_addr   (station_addr),
      .hash_table     (hash_table),
      .verdict_valid  (verdict_valid),
      .verdict_accept (verdict_accept),
      .verdict_mcast  (verdict_mcast)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, test_tag, act, exp, $time);
      end
   endtask

   // Reference hash: CRC-32, poly 0x04C11DB7, preset ones, LSB of each byte first.
   function automatic int ref_index(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int n = 0; n < 48; n++) begin
         logic top = c[31];
         c = c << 1;
         if (top != a[n]) c = c ^ 32'h04C11DB7;
      end
      return int'(c >> 26);
   endfunction

   function automatic bit ref_accept(input logic [47:0] a, input int len, output string tag);
      if (len < 40 && !cfg_runt_ok) begin tag = "R3"; return 1'b0; end
      if (cfg_promisc) begin tag = "R4"; return 1'b1; end
      if (a == 48'hFFFF_FFFF_FFFF) begin tag = "R5"; return cfg_bcast_en; end
      if (a[0]) begin
         if (!cfg_mcast_en) begin tag = "R6"; return 1'b0; end
         tag = "R7";
         return hash_table[ref_index(a)];
      end
      tag = "R8";
      return a == station_addr;
   endfunction

   // Behavioural model: collects bytes, predicts the verdict for the next cycle.
   int          m_cnt = 6;
   logic [47:0] m_addr = '0;
   logic        exp_v = 1'b0, exp_acc = 1'b0, exp_mc = 1'b0;
   string       exp_tag = "";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 6;
         exp_v <= 1'b0;
      end else begin
         exp_v <= 1'b0;
         if (byte_valid && (byte_start || m_cnt < 6)) begin
            string t;
            bit    a;
            if (byte_start) m_cnt = 0;
            m_addr[8*m_cnt +: 8] = byte_data;
            m_cnt++;
            if (m_cnt == 6) begin
               a = ref_accept(m_addr, int'(frame_len), t);
               exp_v   <= 1'b1;
               exp_acc <= a;
               exp_mc  <= m_addr[0];
               exp_tag <= t;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(verdict_valid == exp_v, "R1", verdict_valid, exp_v);
         if (exp_v) begin
            check(verdict_accept == exp_acc, exp_tag, verdict_accept, exp_acc);
            check(verdict_mcast == exp_mc, "R9", verdict_mcast, exp_mc);
         end
      end
   end

   task automatic idle(input int n);
      byte_valid = 1'b0;
      byte_start = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [47:0] a, input int len, input int gap, input int extra);
      frame_len = 16'(len);
      for (int i = 0; i < 6; i++) begin
         byte_valid = 1'b1;
         byte_start = (i == 0);
         byte_data  = a[8*i +: 8];
         @(negedge clk);
         if (gap > 0 && i < 5) idle(gap);
      end
      for (int i = 0; i < extra; i++) begin
         byte_valid = 1'b1;
         byte_start = 1'b0;
         byte_data  = 8'($urandom);
         @(negedge clk);
      end
      idle(2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [47:0] own;
      logic [47:0] grp;
      int          gi;
      own = 48'h5544_3322_1102;
      grp = 48'h0000_005E_0001;
      station_addr = own;
      repeat (3) @(negedge clk);
      // R10: outputs idle in reset
      check(!verdict_valid && !verdict_accept && !verdict_mcast, "R10",
            {verdict_valid, verdict_accept, verdict_mcast}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!verdict_valid && !verdict_accept && !verdict_mcast, "R10",
            {verdict_valid, verdict_accept, verdict_mcast}, 0);

      test_tag = "R8";
      send(own, 64, 0, 0);
      send(own ^ 48'h8000_0000_0000, 64, 0, 0);
      send(own ^ 48'h0000_0000_0004, 64, 1, 3);

      test_tag = "R5";
      send(48'hFFFF_FFFF_FFFF, 64, 0, 0);
      cfg_bcast_en = 1'b1;
      send(48'hFFFF_FFFF_FFFF, 64, 0, 2);
      send(48'hFFFF_FFFF_FEFF, 64, 0, 0);

      test_tag = "R6";
      send(grp, 64, 0, 0);
      test_tag = "R7";
      cfg_mcast_en = 1'b1;
      gi = ref_index(grp);
      hash_table = 64'h1 << gi;
      send(grp, 64, 0, 0);
      hash_table = ~(64'h1 << gi);
      send(grp, 64, 2, 0);
      hash_table = 64'h0;
      send(48'h0000_0000_0033, 64, 0, 0);

      test_tag = "R4";
      cfg_promisc = 1'b1;
      send(48'h1234_5678_9A00, 64, 0, 0);
      test_tag = "R3";
      send(48'h1234_5678_9A00, 39, 0, 0);
      send(48'h1234_5678_9A00, 40, 0, 0);
      cfg_runt_ok = 1'b1;
      send(48'h1234_5678_9A00, 20, 0, 0);
      cfg_runt_ok = 1'b0;
      cfg_promisc = 1'b0;
      send(own, 39, 0, 0);

      // R2: restart in the middle of an address
      test_tag = "R2";
      frame_len = 16'd64;
      for (int i = 0; i < 4; i++) begin
         byte_valid = 1'b1;
         byte_start = (i == 0);
         byte_data  = 8'hFF;
         @(negedge clk);
      end
      send(own, 64, 0, 0);
      for (int i = 0; i < 3; i++) begin
         byte_valid = 1'b1;
         byte_start = (i == 0);
         byte_data  = own[8*i +: 8];
         @(negedge clk);
      end
      idle(3);
      send(48'hFFFF_FFFF_FFFF, 64, 0, 0);

      // R11: config changed right after the sixth byte
      test_tag = "R11";
      frame_len = 16'd64;
      for (int i = 0; i < 6; i++) begin
         byte_valid = 1'b1;
         byte_start = (i == 0);
         byte_data  = own[8*i +: 8];
         @(negedge clk);
      end
      byte_valid = 1'b0;
      station_addr = ~own;
      cfg_promisc  = 1'b1;
      frame_len    = 16'd10;
      idle(2);
      station_addr = own;
      cfg_promisc  = 1'b0;

      test_tag = "random";
      for (int n = 0; n < 200; n++) begin
         logic [47:0] a;
         int          pick;
         pick = $urandom_range(0, 3);
         case (pick)
            0: a = own;
            1: a = 48'hFFFF_FFFF_FFFF;
            2: a = {$urandom, 16'($urandom)} | 48'h1;
            default: a = {$urandom, 16'($urandom)} & ~48'h1;
         endcase
         cfg_promisc  = ($urandom_range(0, 5) == 0);
         cfg_bcast_en = $urandom_range(0, 1);
         cfg_mcast_en = $urandom_range(0, 1);
         cfg_runt_ok  = $urandom_range(0, 1);
         hash_table   = {$urandom, $urandom};
         send(a, $urandom_range(30, 90), $urandom_range(0, 1), $urandom_range(0, 2));
      end

      idle(3);
      finish_run();
   end

endmodule